// File: doc/BRIEF.md
# Thread-Aware Read Request Scorer

This block picks the next DRAM command for a memory controller read path. Each cycle it looks at a snapshot of up to `NE` pending read-side commands. Each entry carries a thread number, a command kind, a channel and rank, a predicted request weight, and two flags: whether the entry is its thread's oldest, and whether it is the last request to its open row. The queue storage lives outside this block and drives that snapshot in.

Per thread, the block derives three values from the snapshot: the pending count, the weight sum and whether that sum is the largest. It keeps a registered blocked/unblocked light per thread and a saturating ticket account that fills at a fixed rate and drains as column reads issue. Every valid entry is scored from its thread's light, its weight standing, its age flag and its thread's pending count. The best entry of each command kind is found first, and then the best of those is registered as the issued command, with an auto-precharge flag when the command closes its row. A thread is reported as priority when its weight sum is large or its ticket account is nearly full.

Top module: `thread_read_scorer`

## Requirements
- R1: A thread's light goes red in the cycle after any of its valid entries targets a channel/rank pair whose bit is set in `refresh_mask`. The bit index is channel × NRK + rank.
- R2: A thread's light goes red in the cycle after any of its valid entries targets a channel whose bit is set in `drain_mask`.
- R3: A thread with no such entries has a green light (`thread_green` bit = 1) one cycle later. All lights are green out of reset.
- R4: An entry's score is the sum of four terms: 4 if its thread is green; 4 if its thread's weight sum equals the largest weight sum over all threads (ties included); 1 if its oldest flag is set; 2 if its thread has exactly one valid entry.
- R5: Command kinds are encoded as 0 = column read, 1 = activate, 2 = precharge, and code 3 is never issued. The best entry of each kind is found first. The highest-scoring of these bests is then issued. On an equal score, column read beats activate, and activate beats precharge.
- R6: Within one command kind, equal scores go to the lowest entry index.
- R7: `out_autopre` is 1 only when the issued command is a column read whose row-last flag is set.
- R8: With no valid entry, `out_valid` is 0 the cycle after.
- R9: A thread's priority bit is set while its weight sum over valid entries is at least `MAX_VALUE`.
- R10: Every NUM_CORES × T_DATA_TRANS × 6 cycles, each thread gains one ticket. A thread loses one ticket in the cycle after the block issues a column read for it. Its priority bit is set while its tickets are at least `MAX_TICKETS` − 8.
- R11: A ticket counter is 7 bits wide. It holds at 127 rather than wrapping, and it never goes below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one DRAM cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | NE | Entry holds a pending command |
| ent_tid | input | NE×TW | Thread number per entry |
| ent_cmd | input | NE×2 | Command kind per entry (0 read, 1 activate, 2 precharge) |
| ent_oldest | input | NE | Entry is the oldest of its thread |
| ent_rowlast | input | NE | Entry is the last request to its row |
| ent_chan | input | NE×CW | Channel per entry |
| ent_rank | input | NE×KW | Rank per entry |
| ent_weight | input | NE×WW | Predicted request weight per entry |
| refresh_mask | input | NCH×NRK | Channel/rank pairs now refreshing |
| drain_mask | input | NCH | Channels now draining writes |
| thread_green | output | NT | Registered light per thread, 1 = green |
| thread_prio | output | NT | Priority flag per thread |
| out_valid | output | 1 | A command is issued this cycle |
| out_idx | output | IW | Entry index of the issued command |
| out_cmd | output | 2 | Kind of the issued command |
| out_tid | output | TW | Thread of the issued command |
| out_autopre | output | 1 | Close the row with this column read |

## Verification
The light appears one edge after a mask or entry change. The issued command appears two edges after a change, because the score uses the lights registered at the first edge and the winner is registered at the second. The bench therefore drives on a falling edge and samples lights one falling edge later and commands two falling edges later. The priority flag follows the weight sum within the same cycle. It follows the ticket account one edge after a tick, and one more edge after an issued read. Ticket checks hold a read entry for a counted number of cycles and expect the flag to fall after a bounded number of them.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2,
    CMD_NONE = 2'd3
  } cmd_e;

  localparam int SCORE_W = 4;
  localparam int TKT_W   = 7;

  // R4: score terms
  function automatic logic [SCORE_W-1:0] score_f(input logic green, input logic top_weight,
                                                 input logic oldest, input logic single);
    logic [SCORE_W-1:0] s;
    s = green ? 4'd4 : 4'd0;
    if (top_weight) s = s + 4'd4;
    if (oldest)     s = s + 4'd1;
    if (single)     s = s + 4'd2;
    return s;
  endfunction

  // R11: saturating ticket step
  function automatic logic [TKT_W-1:0] tkt_next_f(input logic [TKT_W-1:0] cur,
                                                  input logic earn, input logic spend);
    logic [TKT_W-1:0] n;
    n = cur;
    if (earn && !spend && cur != {TKT_W{1'b1}}) n = cur + 1'b1;
    if (spend && !earn && cur != '0)            n = cur - 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/trs_light.sv
module trs_light #(
  parameter int NE  = 8,
  parameter int NT  = 4,
  parameter int NCH = 2,
  parameter int NRK = 2,
  localparam int TW = $clog2(NT),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int KW = (NRK > 1) ? $clog2(NRK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NE-1:0]     ent_valid,
  input  logic [NE*TW-1:0]  ent_tid,
  input  logic [NE*CW-1:0]  ent_chan,
  input  logic [NE*KW-1:0]  ent_rank,
  input  logic [NCH*NRK-1:0] refresh_mask,
  input  logic [NCH-1:0]    drain_mask,
  output logic [NT-1:0]     green
);
  logic [NT-1:0] refresh_hit;
  logic [NT-1:0] drain_hit;

  always_comb begin
    logic [TW-1:0] tv;
    int ch, rk;
    refresh_hit = '0;
    drain_hit   = '0;
    tv = '0;
    for (int e = 0; e < NE; e++) begin
      tv = ent_tid[e*TW +: TW];
      ch = int'(ent_chan[e*CW +: CW]);
      rk = int'(ent_rank[e*KW +: KW]);
      if (ent_valid[e] && int'(tv) < NT && ch < NCH && rk < NRK) begin
        if (refresh_mask[ch*NRK + rk]) refresh_hit[tv] = 1'b1;
        if (drain_mask[ch])            drain_hit[tv]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) green <= '1;
    else        green <= ~(refresh_hit | drain_hit);
  end

  // R3
  light_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_mask == '0 && drain_mask == '0) |=> (green == '1));
endmodule

// File: rtl/trs_thread_stats.sv
module trs_thread_stats #(
  parameter int NE           = 8,
  parameter int NT           = 4,
  parameter int WW           = 12,
  parameter int MAX_VALUE    = 1024,
  parameter int MAX_TICKETS  = 64,
  parameter int NUM_CORES    = 2,
  parameter int T_DATA_TRANS = 4,
  localparam int TW     = $clog2(NT),
  localparam int IW     = $clog2(NE),
  localparam int SW     = WW + IW + 1,
  localparam int PERIOD = NUM_CORES * T_DATA_TRANS * 6,
  localparam int DW     = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NE-1:0]    ent_valid,
  input  logic [NE*TW-1:0] ent_tid,
  input  logic [NE*WW-1:0] ent_weight,
  input  logic             spend_valid,
  input  logic [TW-1:0]    spend_tid,
  output logic [NT-1:0]    single,
  output logic [NT-1:0]    top_weight,
  output logic [NT-1:0]    prio
);
  import trs_pkg::*;

  logic [IW:0]       cnt [NT];
  logic [SW-1:0]     wsum [NT];
  logic [SW-1:0]     wmax;
  logic [DW-1:0]     div_q;
  logic              tick;
  logic [TKT_W-1:0]  tkt [NT];

  always_comb begin
    logic [TW-1:0] tv;
    tv = '0;
    for (int t = 0; t < NT; t++) begin
      cnt[t]  = '0;
      wsum[t] = '0;
    end
    for (int e = 0; e < NE; e++) begin
      tv = ent_tid[e*TW +: TW];
      if (ent_valid[e] && int'(tv) < NT) begin
        cnt[tv]  = cnt[tv] + 1'b1;
        wsum[tv] = wsum[tv] + SW'(ent_weight[e*WW +: WW]);
      end
    end
    wmax = '0;
    for (int t = 0; t < NT; t++) if (wsum[t] > wmax) wmax = wsum[t];
    for (int t = 0; t < NT; t++) begin
      single[t]     = (cnt[t] == (IW+1)'(1));
      top_weight[t] = (wsum[t] == wmax);
      prio[t]       = (wsum[t] >= SW'(MAX_VALUE)) ||
                      (int'(tkt[t]) >= MAX_TICKETS - 8);
    end
  end

  assign tick = (div_q == DW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (!rst_n) tkt[t] <= '0;
      else        tkt[t] <= tkt_next_f(tkt[t], tick, spend_valid && spend_tid == TW'(t));
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_tkt_chk
    // R10
    tkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, tkt[g]} == {1'b0, $past(tkt[g])}) ||
      ({1'b0, tkt[g]} == {1'b0, $past(tkt[g])} + 8'd1) ||
      ({1'b0, tkt[g]} + 8'd1 == {1'b0, $past(tkt[g])}));
    // R11
    tkt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tkt[g] == {TKT_W{1'b1}} && !(spend_valid && spend_tid == TW'(g))) |=> (tkt[g] == {TKT_W{1'b1}}));
  end
endmodule

// File: rtl/trs_pick.sv
module trs_pick #(
  parameter int NE = 8,
  parameter int NT = 4,
  localparam int TW = $clog2(NT),
  localparam int IW = $clog2(NE)
) (
  input  logic [NE-1:0]    ent_valid,
  input  logic [NE*TW-1:0] ent_tid,
  input  logic [NE*2-1:0]  ent_cmd,
  input  logic [NE-1:0]    ent_oldest,
  input  logic [NT-1:0]    green,
  input  logic [NT-1:0]    top_weight,
  input  logic [NT-1:0]    single,
  output logic             pick_valid,
  output logic [IW-1:0]    pick_idx,
  output logic [1:0]       pick_cmd
);
  import trs_pkg::*;

  logic [SCORE_W-1:0] sc [NE];
  logic               bv [3];
  logic [IW-1:0]      bi [3];
  logic [SCORE_W-1:0] bs [3];
  logic [SCORE_W-1:0] ps;

  always_comb begin
    logic [TW-1:0] tv;
    tv = '0;
    for (int e = 0; e < NE; e++) begin
      tv = ent_tid[e*TW +: TW];
      sc[e] = score_f(green[tv], top_weight[tv], ent_oldest[e], single[tv]);
    end
    // R6: strict compare keeps the lowest index on a tie
    for (int k = 0; k < 3; k++) begin
      bv[k] = 1'b0;
      bi[k] = '0;
      bs[k] = '0;
      for (int e = 0; e < NE; e++) begin
        if (ent_valid[e] && int'(tv) >= 0 && ent_cmd[e*2 +: 2] == 2'(k) &&
            (!bv[k] || sc[e] > bs[k])) begin
          bv[k] = 1'b1;
          bi[k] = IW'(e);
          bs[k] = sc[e];
        end
      end
    end
    // R5: kinds visited read, activate, precharge; strict compare gives that tie order
    pick_valid = 1'b0;
    pick_idx   = '0;
    pick_cmd   = CMD_NONE;
    ps         = '0;
    for (int k = 0; k < 3; k++) begin
      if (bv[k] && (!pick_valid || bs[k] > ps)) begin
        pick_valid = 1'b1;
        pick_idx   = bi[k];
        pick_cmd   = 2'(k);
        ps         = bs[k];
      end
    end
  end
endmodule

// File: rtl/thread_read_scorer.sv
module thread_read_scorer #(
  parameter int NE           = 8,
  parameter int NT           = 4,
  parameter int NCH          = 2,
  parameter int NRK          = 2,
  parameter int WW           = 12,
  parameter int MAX_VALUE    = 1024,
  parameter int MAX_TICKETS  = 64,
  parameter int NUM_CORES    = 2,
  parameter int T_DATA_TRANS = 4,
  localparam int TW = $clog2(NT),
  localparam int IW = $clog2(NE),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int KW = (NRK > 1) ? $clog2(NRK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NE-1:0]      ent_valid,
  input  logic [NE*TW-1:0]   ent_tid,
  input  logic [NE*2-1:0]    ent_cmd,
  input  logic [NE-1:0]      ent_oldest,
  input  logic [NE-1:0]      ent_rowlast,
  input  logic [NE*CW-1:0]   ent_chan,
  input  logic [NE*KW-1:0]   ent_rank,
  input  logic [NE*WW-1:0]   ent_weight,
  input  logic [NCH*NRK-1:0] refresh_mask,
  input  logic [NCH-1:0]     drain_mask,
  output logic [NT-1:0]      thread_green,
  output logic [NT-1:0]      thread_prio,
  output logic               out_valid,
  output logic [IW-1:0]      out_idx,
  output logic [1:0]         out_cmd,
  output logic [TW-1:0]      out_tid,
  output logic               out_autopre
);
  import trs_pkg::*;

  logic [NT-1:0] single, top_weight;
  logic          pick_valid;
  logic [IW-1:0] pick_idx;
  logic [1:0]    pick_cmd;
  logic          rd_spend;

  trs_light #(.NE(NE), .NT(NT), .NCH(NCH), .NRK(NRK)) u_light (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_tid(ent_tid),
    .ent_chan(ent_chan), .ent_rank(ent_rank), .refresh_mask(refresh_mask),
    .drain_mask(drain_mask), .green(thread_green));

  assign rd_spend = out_valid && out_cmd == CMD_RD;

  trs_thread_stats #(.NE(NE), .NT(NT), .WW(WW), .MAX_VALUE(MAX_VALUE),
                     .MAX_TICKETS(MAX_TICKETS), .NUM_CORES(NUM_CORES),
                     .T_DATA_TRANS(T_DATA_TRANS)) u_stats (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_tid(ent_tid),
    .ent_weight(ent_weight), .spend_valid(rd_spend), .spend_tid(out_tid),
    .single(single), .top_weight(top_weight), .prio(thread_prio));

  trs_pick #(.NE(NE), .NT(NT)) u_pick (
    .ent_valid(ent_valid), .ent_tid(ent_tid), .ent_cmd(ent_cmd),
    .ent_oldest(ent_oldest), .green(thread_green), .top_weight(top_weight),
    .single(single), .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_cmd(pick_cmd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_idx     <= '0;
      out_cmd     <= CMD_NONE;
      out_tid     <= '0;
      out_autopre <= 1'b0;
    end else begin
      out_valid   <= pick_valid;
      out_idx     <= pick_idx;
      out_cmd     <= pick_cmd;
      out_tid     <= ent_tid[pick_idx*TW +: TW];
      out_autopre <= pick_valid && pick_cmd == CMD_RD && ent_rowlast[pick_idx];
    end
  end

  // R7
  autopre_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_autopre |-> (out_valid && out_cmd == CMD_RD));
  // R8
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ent_valid) == '0) |-> !out_valid);
  // R5
  pick_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((($past(ent_valid) >> out_idx) & NE'(1)) != '0 && out_cmd != CMD_NONE));
endmodule

// File: tb/thread_read_scorer_bench.sv
module thread_read_scorer_bench;
  localparam int NE = 8, NT = 4, NCH = 2, NRK = 2, WW = 12;
  localparam int MAXV = 1024, MAXT = 64, PER = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] ent_valid, ent_oldest, ent_rowlast;
  logic [NE*2-1:0] ent_tid, ent_cmd;
  logic [NE-1:0] ent_chan, ent_rank;
  logic [NE*WW-1:0] ent_weight;
  logic [3:0] refresh_mask;
  logic [1:0] drain_mask;
  logic [NT-1:0] thread_green, thread_prio;
  logic out_valid, out_autopre;
  logic [2:0] out_idx;
  logic [1:0] out_cmd, out_tid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  thread_read_scorer #(.NE(NE), .NT(NT), .NCH(NCH), .NRK(NRK), .WW(WW),
    .MAX_VALUE(MAXV), .MAX_TICKETS(MAXT), .NUM_CORES(2), .T_DATA_TRANS(4)) u_thread_read_scorer (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_tid(ent_tid), .ent_cmd(ent_cmd),
    .ent_oldest(ent_oldest), .ent_rowlast(ent_rowlast), .ent_chan(ent_chan), .ent_rank(ent_rank),
    .ent_weight(ent_weight), .refresh_mask(refresh_mask), .drain_mask(drain_mask),
    .thread_green(thread_green), .thread_prio(thread_prio), .out_valid(out_valid),
    .out_idx(out_idx), .out_cmd(out_cmd), .out_tid(out_tid), .out_autopre(out_autopre));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    ent_valid = '0; ent_tid = '0; ent_cmd = '0; ent_oldest = '0; ent_rowlast = '0;
    ent_chan = '0; ent_rank = '0; ent_weight = '0; refresh_mask = '0; drain_mask = '0;
  endtask

  task automatic put(int i, int tid, int cmd, bit old, bit last, int ch, int rk, int w);
    ent_valid[i] = 1'b1; ent_tid[i*2 +: 2] = 2'(tid); ent_cmd[i*2 +: 2] = 2'(cmd);
    ent_oldest[i] = old; ent_rowlast[i] = last; ent_chan[i] = ch[0]; ent_rank[i] = rk[0];
    ent_weight[i*WW +: WW] = WW'(w);
  endtask

  task automatic t_reset();
    chk("R8 reset out_valid", out_valid, 0);
    chk("R3 reset lights", thread_green, 4'hF);
    chk("R10 reset prio", thread_prio, 0);
  endtask

  // Scores: e0 red t0 3, e1 4, e3 5, e2 green+top+old+single 11
  task automatic t_scoring();
    clear_all();
    refresh_mask = 4'b0001;
    put(0, 0, 0, 1, 0, 0, 0, 10);
    put(1, 1, 0, 0, 0, 1, 1, 10);
    put(2, 2, 1, 1, 0, 1, 0, 50);
    put(3, 1, 0, 1, 1, 1, 1, 10);
    step(2);
    chk("R1 refresh red", thread_green, 4'b1110);
    chk("R4 winner idx", out_idx, 2);
    chk("R5 winner cmd", out_cmd, 1);
    chk("R7 no autopre on act", out_autopre, 0);
    ent_valid[2] = 1'b0;
    step(2);
    chk("R4 second winner idx", out_idx, 3);
    chk("R7 autopre on last read", out_autopre, 1);
    ent_rowlast[3] = 1'b0;
    step(2);
    chk("R7 no autopre without row-last", out_autopre, 0);
  endtask

  task automatic t_drain();
    clear_all();
    drain_mask = 2'b10;
    put(0, 3, 2, 0, 0, 1, 0, 5);
    put(1, 0, 2, 0, 0, 0, 1, 5);
    step(2);
    chk("R2 drain red", thread_green, 4'b0111);
    // t0: 4+4+0+2=10 beats t3: 0+4+0+2=6
    chk("R2 red loses", out_idx, 1);
    drain_mask = 2'b00;
    step(2);
    chk("R3 lights recover", thread_green, 4'hF);
  endtask

  task automatic t_ties();
    clear_all();
    put(0, 0, 2, 1, 0, 0, 0, 7);
    put(1, 1, 1, 1, 0, 0, 0, 7);
    step(2);
    chk("R5 act beats pre cmd", out_cmd, 1);
    chk("R5 act beats pre idx", out_idx, 1);
    clear_all();
    put(4, 2, 1, 1, 0, 1, 1, 7);
    put(5, 3, 1, 1, 0, 1, 1, 7);
    step(2);
    chk("R6 lowest index", out_idx, 4);
    clear_all();
    put(0, 0, 1, 1, 0, 0, 0, 7);
    put(6, 1, 0, 1, 0, 0, 0, 7);
    step(2);
    chk("R5 read beats act", out_idx, 6);
    clear_all();
    step(2);
    chk("R8 empty no issue", out_valid, 0);
  endtask

  task automatic t_weight();
    clear_all();
    put(0, 2, 1, 0, 0, 0, 0, MAXV - 24);
    put(1, 2, 1, 0, 0, 0, 0, 23);
    step(1);
    chk("R9 below weight limit", thread_prio, 0);
    ent_weight[1*WW +: WW] = WW'(24);
    step(1);
    chk("R9 at weight limit", thread_prio, 4'b0100);
    clear_all();
    step(2);
  endtask

  task automatic t_tickets();
    int n;
    clear_all();
    n = 0;
    while (!thread_prio[0] && n < 100*PER) begin step(1); n++; end
    chk("R10 tickets raise prio", thread_prio[0], 1);
    put(0, 0, 0, 0, 0, 0, 0, 1);
    step(1);
    clear_all();
    step(1);
    chk("R10 spend drops prio", thread_prio[0], 0);
    step(150 * PER);
    chk("R11 full account prio", thread_prio[0], 1);
    put(0, 0, 0, 0, 0, 0, 0, 1);
    n = 0;
    while (thread_prio[0] && n < 300) begin step(1); n++; end
    clear_all();
    n_chk++;
    if (n < 72 || n > 76) begin
      n_bad++;
      $display("FAIL R11 cycles to drain from 127 actual=%0d expected=72..76", n);
    end
  endtask

  initial begin
    clear_all();
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_scoring();
    t_drain();
    t_ties();
    t_weight();
    t_tickets();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule